// File: doc/BRIEF.md
# Two-Level Translation Table Walker

This block runs after a translation lookaside buffer misses. It takes a 32-bit virtual address and reads one or two descriptors from memory. From them it produces a physical address of up to 40 bits, a page-size code and an attribute field, or it reports a translation fault. Two table base addresses are supplied. A split count decides which base serves a request. If every bit in the top `split_n` bits of the address is zero, the walk uses `tbl_base0`. Otherwise it uses `tbl_base1`.

The first-level descriptor can fault, finish the walk as a 1 MB or 16 MB block, or point to a second-level table. A second-level descriptor finishes the walk as a 64 KB page, finishes it as a 4 KB page, or faults. Memory is read through a request strobe, an address, and a response valid that may arrive any number of cycles (at least one) after the strobe. Only one walk runs at a time. `busy` covers the walk, and `done` is a one-cycle pulse that carries the result.

Top module: `table_walker`

## Requirements
- R1: After reset, `busy`, `done`, `fault` and `mem_req` are all low.
- R2: The walk uses `tbl_base0` when `req_va` bits [31:32-N] are all zero, where N = `split_n`, and uses `tbl_base1` otherwise. With N = 0, `tbl_base0` is always used. `split_n` and both bases are captured when the request is accepted.
- R3: The first read goes to base + 4 × VA[31:20]. Each read raises `mem_req` for exactly one cycle. The walker waits for `mem_rvalid` for however many cycles it takes, and ignores `mem_rvalid` when no read is pending.
- R4: A first-level descriptor with bits [1:0] = 00 ends the walk with `fault` = 1 in the `done` cycle. In that case `pa`, `pg_size` and `attr` are zero and no second read is made.
- R5: A first-level descriptor with type 10 and bit 18 clear is a 1 MB block. `pa` = {8'h00, desc[31:20], VA[19:0]}, `pg_size` = 2 and `attr` = desc[9:2].
- R6: A first-level descriptor with type 10 and bit 18 set is a 16 MB block. `pa` = {desc[17:10], desc[31:24], VA[23:0]}, `pg_size` = 3 and `attr` = desc[9:2].
- R7: A first-level descriptor with type 01 starts a second read at {desc[31:10], 10'b0} + 4 × VA[19:12]. A 64 KB entry is therefore repeated by software over its 16 slots, and VA[19:16] selects the group.
- R8: A second-level descriptor with type 01 is a 64 KB page. `pa` = {8'h00, desc[31:16], VA[15:0]}, `pg_size` = 1 and `attr` = desc[9:2].
- R9: A second-level descriptor with type 10 or 11 is a 4 KB page. `pa` = {8'h00, desc[31:12], VA[11:0]}, `pg_size` = 0 and `attr` = desc[9:2].
- R10: A second-level descriptor with type 00 ends the walk with a fault, and the result fields are zero.
- R11: A first-level descriptor with type 11 is reserved and ends the walk with a fault after a single read.
- R12: `busy` is high from the cycle after acceptance until `done`. `done` lasts one cycle, and `busy` is low during it. A `req_valid` seen while busy is ignored. A request presented in the `done` cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Start a walk (taken only when idle) |
| req_va | input | 32 | Virtual address to translate |
| split_n | input | 3 | Number of top address bits that must be zero to use base 0 |
| tbl_base0 | input | 32 | First-level table base for the low region |
| tbl_base1 | input | 32 | First-level table base for the high region |
| busy | output | 1 | Walk in progress |
| mem_req | output | 1 | One-cycle descriptor read strobe |
| mem_addr | output | 32 | Descriptor read address |
| mem_rvalid | input | 1 | Descriptor data valid |
| mem_rdata | input | 32 | Descriptor data |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Translation fault, valid with done |
| pa | output | 40 | Physical address, valid with done |
| pg_size | output | 2 | 0 = 4 KB, 1 = 64 KB, 2 = 1 MB, 3 = 16 MB |
| attr | output | 8 | Attribute bits from the final descriptor |

## Verification
Completion and acceptance of a new walk can fall in the same cycle, because the state is idle while `done` is high. The bench raises `req_valid` for a second address in exactly the cycle it sees `done` for the first. It then checks that both the first result and the second walk's read address and result are correct. The bench also raises `req_valid` mid-walk, where it must not overlap the running walk. For that case it confirms that the number of reads and the result belong to the first address only.

// File: rtl/tw_pkg.sv
package tw_pkg;
  localparam int VA_W    = 32;
  localparam int PA_W    = 40;
  localparam int SPLIT_W = 3;
  localparam int ATTR_W  = 8;
  localparam int L2_ALN  = 10;

  typedef enum logic [1:0] {
    SZ_4K  = 2'd0,
    SZ_64K = 2'd1,
    SZ_1M  = 2'd2,
    SZ_16M = 2'd3
  } pg_size_e;

  // true when the top n bits of va are zero
  function automatic logic top_clear(logic [VA_W-1:0] va, logic [SPLIT_W-1:0] n);
    logic [VA_W-1:0] m;
    m = ~({VA_W{1'b1}} >> n);
    return (va & m) == '0;
  endfunction

  function automatic logic [VA_W-1:0] l1_addr(logic [VA_W-1:0] base, logic [VA_W-1:0] va);
    return base + {18'b0, va[31:20], 2'b00};
  endfunction

  function automatic logic [VA_W-1:0] l2_addr(logic [31:0] desc, logic [VA_W-1:0] va);
    return {desc[31:L2_ALN], {L2_ALN{1'b0}}} + {22'b0, va[19:12], 2'b00};
  endfunction

  function automatic logic [PA_W-1:0] pa_1m(logic [31:0] d, logic [VA_W-1:0] va);
    return {8'h00, d[31:20], va[19:0]};
  endfunction

  function automatic logic [PA_W-1:0] pa_16m(logic [31:0] d, logic [VA_W-1:0] va);
    return {d[17:10], d[31:24], va[23:0]};
  endfunction

  function automatic logic [PA_W-1:0] pa_64k(logic [31:0] d, logic [VA_W-1:0] va);
    return {8'h00, d[31:16], va[15:0]};
  endfunction

  function automatic logic [PA_W-1:0] pa_4k(logic [31:0] d, logic [VA_W-1:0] va);
    return {8'h00, d[31:12], va[11:0]};
  endfunction
endpackage

// File: rtl/tw_base_sel.sv
module tw_base_sel
  import tw_pkg::*;
(
  input  logic [VA_W-1:0]    va,
  input  logic [SPLIT_W-1:0] split_n,
  input  logic [VA_W-1:0]    base0,
  input  logic [VA_W-1:0]    base1,
  output logic               use_hi,
  output logic [VA_W-1:0]    first_addr
);
  logic [VA_W-1:0] base_pick;

  assign use_hi     = !top_clear(va, split_n);
  assign base_pick  = use_hi ? base1 : base0;
  assign first_addr = l1_addr(base_pick, va);
endmodule

// File: rtl/tw_desc_decode.sv
module tw_desc_decode
  import tw_pkg::*;
(
  input  logic              second,
  input  logic [31:0]       desc,
  input  logic [VA_W-1:0]   va,
  output logic              is_fault,
  output logic              is_table,
  output logic [PA_W-1:0]   res_pa,
  output pg_size_e          res_size,
  output logic [ATTR_W-1:0] res_attr,
  output logic [VA_W-1:0]   next_addr
);
  assign next_addr = l2_addr(desc, va);

  always_comb begin
    is_fault = 1'b0;
    is_table = 1'b0;
    res_pa   = '0;
    res_size = SZ_4K;
    res_attr = '0;
    if (!second) begin
      unique case (desc[1:0])
        2'b01: is_table = 1'b1;
        2'b10: begin
          res_attr = desc[9:2];
          if (desc[18]) begin
            res_pa   = pa_16m(desc, va);
            res_size = SZ_16M;
          end else begin
            res_pa   = pa_1m(desc, va);
            res_size = SZ_1M;
          end
        end
        default: is_fault = 1'b1;
      endcase
    end else begin
      unique case (desc[1:0])
        2'b00: is_fault = 1'b1;
        2'b01: begin
          res_attr = desc[9:2];
          res_pa   = pa_64k(desc, va);
          res_size = SZ_64K;
        end
        default: begin
          res_attr = desc[9:2];
          res_pa   = pa_4k(desc, va);
          res_size = SZ_4K;
        end
      endcase
    end
  end
endmodule

// File: rtl/table_walker.sv
module table_walker
  import tw_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [VA_W-1:0]    req_va,
  input  logic [SPLIT_W-1:0] split_n,
  input  logic [VA_W-1:0]    tbl_base0,
  input  logic [VA_W-1:0]    tbl_base1,
  output logic               busy,
  output logic               mem_req,
  output logic [VA_W-1:0]    mem_addr,
  input  logic               mem_rvalid,
  input  logic [31:0]        mem_rdata,
  output logic               done,
  output logic               fault,
  output logic [PA_W-1:0]    pa,
  output logic [1:0]         pg_size,
  output logic [ATTR_W-1:0]  attr
);
  typedef enum logic [2:0] {S_IDLE, S_RD1, S_WT1, S_RD2, S_WT2} st_e;

  st_e               state;
  logic [VA_W-1:0]   va_q;
  logic [VA_W-1:0]   addr_q;
  logic              done_q, fault_q;
  logic [PA_W-1:0]   pa_q;
  pg_size_e          size_q;
  logic [ATTR_W-1:0] attr_q;

  logic              sel_hi;
  logic [VA_W-1:0]   sel_addr;
  logic              dec_fault, dec_table;
  logic [PA_W-1:0]   dec_pa;
  pg_size_e          dec_size;
  logic [ATTR_W-1:0] dec_attr;
  logic [VA_W-1:0]   dec_next;

  // named events
  logic ev_accept, ev_resp, ev_descend, ev_finish;
  assign ev_accept  = (state == S_IDLE) && req_valid;
  assign ev_resp    = mem_rvalid && ((state == S_WT1) || (state == S_WT2));
  assign ev_descend = ev_resp && (state == S_WT1) && dec_table;
  assign ev_finish  = ev_resp && !ev_descend;

  tw_base_sel u_sel (
    .va         (req_va),
    .split_n    (split_n),
    .base0      (tbl_base0),
    .base1      (tbl_base1),
    .use_hi     (sel_hi),
    .first_addr (sel_addr)
  );

  tw_desc_decode u_dec (
    .second    (state == S_WT2),
    .desc      (mem_rdata),
    .va        (va_q),
    .is_fault  (dec_fault),
    .is_table  (dec_table),
    .res_pa    (dec_pa),
    .res_size  (dec_size),
    .res_attr  (dec_attr),
    .next_addr (dec_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      va_q    <= '0;
      addr_q  <= '0;
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      pa_q    <= '0;
      size_q  <= SZ_4K;
      attr_q  <= '0;
    end else begin
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      unique case (state)
        S_IDLE: if (ev_accept) begin
          va_q   <= req_va;
          addr_q <= sel_addr;
          state  <= S_RD1;
        end
        S_RD1: state <= S_WT1;
        S_RD2: state <= S_WT2;
        default: ;
      endcase
      if (ev_descend) begin
        addr_q <= dec_next;
        state  <= S_RD2;
      end else if (ev_finish) begin
        done_q  <= 1'b1;
        fault_q <= dec_fault;
        pa_q    <= dec_pa;
        size_q  <= dec_size;
        attr_q  <= dec_attr;
        state   <= S_IDLE;
      end
    end
  end

  assign busy     = (state != S_IDLE);
  assign mem_req  = (state == S_RD1) || (state == S_RD2);
  assign mem_addr = addr_q;
  assign done     = done_q;
  assign fault    = fault_q;
  assign pa       = pa_q;
  assign pg_size  = size_q;
  assign attr     = attr_q;

  AST_REQ_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req); // R3
  AST_READ_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> mem_req); // R3
  AST_FAULT_IN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> done); // R4
  AST_FAULT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (pa == '0 && attr == '0 && pg_size == 2'd0)); // R4
  AST_SUPER_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !fault && pg_size == 2'd3) |-> (pa[23:0] == va_q[23:0])); // R6
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R12
  AST_BUSY_ENDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done); // R12
endmodule

// File: tb/table_walker_tb.sv
module table_walker_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_va = '0;
  logic [2:0]  split_n = '0;
  logic [31:0] tbl_base0 = 32'h0010_0000;
  logic [31:0] tbl_base1 = 32'h0020_0000;
  logic        busy, mem_req, done, fault;
  logic [31:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic [39:0] pa;
  logic [1:0]  pg_size;
  logic [7:0]  attr;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  table_walker u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va),
    .split_n(split_n), .tbl_base0(tbl_base0), .tbl_base1(tbl_base1),
    .busy(busy), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .done(done),
    .fault(fault), .pa(pa), .pg_size(pg_size), .attr(attr)
  );

  // memory responder
  logic [31:0] d1, d2;
  logic [31:0] rd_log [2];
  int nrd = 0;
  int lat = 1;
  int pend = 0;
  always @(negedge clk) begin
    mem_rvalid = 1'b0;
    if (mem_req) begin
      if (nrd < 2) rd_log[nrd] = mem_addr;
      nrd = nrd + 1;
      pend = lat;
    end else if (pend > 0) begin
      pend = pend - 1;
      if (pend == 0) begin
        mem_rvalid = 1'b1;
        mem_rdata  = (nrd <= 1) ? d1 : d2;
      end
    end
  end

  logic        g_fault;
  logic [39:0] g_pa;
  logic [1:0]  g_size;
  logic [7:0]  g_attr;
  logic        g_ok;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic ref_hi(logic [31:0] va, int n);
    for (int i = 0; i < n; i++) if (va[31-i]) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [31:0] ref_l1(logic [31:0] va, int n);
    logic [31:0] b;
    b = ref_hi(va, n) ? tbl_base1 : tbl_base0;
    return b + (va >> 20) * 4;
  endfunction

  task automatic wait_done();
    g_ok = 1'b0;
    for (int c = 0; c < 300; c++) begin
      @(negedge clk);
      if (done) begin
        g_ok = 1'b1; g_fault = fault; g_pa = pa; g_size = pg_size; g_attr = attr;
        break;
      end
    end
    if (!g_ok) begin errors++; $display("FAIL R12: walk never completed actual=0 expected=1"); end
  endtask

  task automatic walk(logic [31:0] va, int n, int l);
    @(negedge clk);
    nrd = 0; lat = l;
    req_va = va; split_n = n[2:0]; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R12 busy after accept", busy, 1);
    wait_done();
    chk("R12 busy low in done", busy, 0);
  endtask

  task automatic t_reset();
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 fault", fault, 0);
    chk("R1 mem_req", mem_req, 0);
  endtask

  task automatic t_section();
    logic [31:0] va = 32'h1234_5678;
    d1 = (32'hABC << 20) | (32'h5A << 2) | 32'h2;
    walk(va, 2, 1);
    chk("R2/R3 l1 addr base0", rd_log[0], ref_l1(va, 2));
    chk("R5 pa", g_pa, {8'h00, 12'hABC, va[19:0]});
    chk("R5 size", g_size, 2);
    chk("R5 attr", g_attr, 8'h5A);
    chk("R5 fault", g_fault, 0);
    @(negedge clk);
    chk("R12 done one cycle", done, 0);
  endtask

  task automatic t_split();
    d1 = (32'h111 << 20) | 32'h2;
    walk(32'h4000_0000, 2, 1);
    chk("R2 base1 selected", rd_log[0], tbl_base1 + 32'h400 * 4);
    walk(32'hF123_0000, 0, 2);
    chk("R2 n=0 uses base0", rd_log[0], tbl_base0 + 32'hF12 * 4);
    walk(32'h01F0_0000, 7, 1);
    chk("R2 n=7 top clear", rd_log[0], ref_l1(32'h01F0_0000, 7));
    chk("R2 n=7 top clear base0", rd_log[0], tbl_base0 + 32'h01F * 4);
    walk(32'h0200_0000, 7, 1);
    chk("R2 n=7 bit25 base1", rd_log[0], tbl_base1 + 32'h020 * 4);
  endtask

  task automatic t_super();
    logic [31:0] va = 32'h0D87_6543;
    d1 = (32'h9C << 24) | (32'h1 << 18) | (32'hE7 << 10) | (32'h3C << 2) | 32'h2;
    walk(va, 3, 4);
    chk("R6 pa", g_pa, 40'hE7_9C87_6543);
    chk("R6 size", g_size, 3);
    chk("R6 attr", g_attr, 8'h3C);
    chk("R3 single read", nrd, 1);
  endtask

  task automatic t_l1_faults();
    d1 = 32'hFFFF_FFFC;
    walk(32'h2000_1000, 1, 1);
    chk("R4 fault", g_fault, 1);
    chk("R4 pa zero", g_pa, 0);
    chk("R4 attr zero", g_attr, 0);
    chk("R4 one read", nrd, 1);
    d1 = 32'h1234_5673;
    walk(32'h2000_1000, 1, 1);
    chk("R11 type11 fault", g_fault, 1);
    chk("R11 one read", nrd, 1);
  endtask

  task automatic t_pages();
    logic [31:0] va = 32'h7A5B_C123;
    d1 = 32'h0804_3C01;
    d2 = (32'hCAFE1 << 12) | (32'h81 << 2) | 32'h2;
    walk(va, 1, 1);
    chk("R7 l2 addr", rd_log[1], 32'h0804_3C00 + 32'hBC * 4);
    chk("R7 two reads", nrd, 2);
    chk("R9 small pa", g_pa, {8'h00, 20'hCAFE1, 12'h123});
    chk("R9 small size", g_size, 0);
    chk("R9 small attr", g_attr, 8'h81);
    d2 = (32'h13579 << 12) | 32'h3;
    walk(va, 1, 3);
    chk("R9 type11 small pa", g_pa, {8'h00, 20'h13579, 12'h123});
    d2 = (32'hBEEF << 16) | (32'h42 << 2) | 32'h1;
    walk(va, 1, 2);
    chk("R8 large pa", g_pa, {8'h00, 16'hBEEF, 16'hC123});
    chk("R8 large size", g_size, 1);
    chk("R8 large attr", g_attr, 8'h42);
    d2 = 32'hFFFF_FFFC;
    walk(va, 1, 1);
    chk("R10 l2 fault", g_fault, 1);
    chk("R10 pa zero", g_pa, 0);
  endtask

  task automatic t_busy_ignore();
    d1 = 32'h0804_3C01;
    d2 = (32'hCAFE1 << 12) | 32'h2;
    @(negedge clk);
    nrd = 0; lat = 3;
    req_va = 32'h7A5B_C123; split_n = 3'd1; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    req_va = 32'h0000_0000; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    wait_done();
    chk("R12 ignored while busy pa", g_pa, {8'h00, 20'hCAFE1, 12'h123});
    chk("R12 ignored while busy reads", nrd, 2);
    @(negedge clk);
    chk("R12 idle after ignore", busy, 0);
  endtask

  task automatic t_back_to_back();
    d1 = (32'h321 << 20) | 32'h2;
    walk(32'h0015_0000, 0, 1);
    chk("R12 b2b first pa", g_pa, {8'h00, 12'h321, 20'h50000});
    nrd = 0;
    req_va = 32'h0AB0_0004; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R12 accepted in done cycle", busy, 1);
    wait_done();
    chk("R12 b2b l1 addr", rd_log[0], tbl_base0 + 32'h0AB * 4);
    chk("R12 b2b second pa", g_pa, {8'h00, 12'h321, 20'h00004});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_section();
    t_split();
    t_super();
    t_l1_faults();
    t_pages();
    t_busy_ignore();
    t_back_to_back();
    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule